// File: doc/BRIEF.md
# Receive Destination Address Screen

This block sits at the front of an Ethernet receive path. It decides whether an incoming frame is kept by looking only at the frame's 48-bit destination address. The six address bytes arrive one per strobe, first byte first. A start marker on the first byte opens a new address. After the sixth byte the block raises a one-cycle decision strobe with an accept flag beside it.

Three kinds of address are told apart. A unicast address is kept only when it equals the programmed station address. The all-ones broadcast address is kept unless broadcast rejection is switched on. Any other address with the group bit set is a multicast address. For a multicast address the block runs a CRC-32 over the six bytes and uses six bits of the result to pick one bit of a 64-bit hash table. The frame is kept when that bit is 1. A promiscuous mode input keeps every frame, whatever its address.

Top module: `dst_addr_screen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `decisionValid` and `accept` are both 0.
- R2: `decisionValid` is 1 for exactly one cycle: the cycle after the clock edge that samples the sixth counted address byte. Idle cycles (with `byteValid` low) may appear between address bytes.
- R3: A byte sampled with both `byteValid` and `frameStart` high is address byte 0. This holds even in the middle of an address, where it restarts the count.
- R4: Bytes sampled after the sixth byte, and before the next start marker, have no effect. They produce no decision and leave `accept` unchanged.
- R5: The station address is byte0=`stationHi[15:8]`, byte1=`stationHi[7:0]`, byte2=`stationLo[31:24]`, byte3=`stationLo[23:16]`, byte4=`stationLo[15:8]` and byte5=`stationLo[7:0]`. An address with bit 0 of byte 0 clear is unicast. It is accepted only when all six bytes equal the station address.
- R6: The all-ones address is accepted when `rejectBcast` is 0 and rejected when it is 1. This applies when `promisc` is 0.
- R7: An address that is not all ones and has bit 0 of byte 0 set is multicast. The CRC for it runs as follows:
  - The register starts at 0xFFFFFFFF.
  - Each byte is taken LSB first.
  - Each bit step is: shift right, then XOR with 0xEDB88320 when (old bit 0 XOR data bit) is 1.
  - There is no final inversion.

  The index is bits 31:26 of the CRC. Index bit 5 selects `hashHi` (1) or `hashLo` (0), and index bits 4:0 select the bit within it. The frame is accepted if that bit is 1.
- R8: When `promisc` is 1, every address is accepted. This includes broadcast while `rejectBcast` is 1.
- R9: `accept` holds the last decision until the next decision strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | Address byte strobe |
| frameStart | input | 1 | Marks byte 0 when high with byteValid |
| byteData | input | 8 | Destination address byte |
| stationLo | input | 32 | Station address bytes 2..5 |
| stationHi | input | 16 | Station address bytes 0..1 |
| hashLo | input | 32 | Hash table bits 0..31 |
| hashHi | input | 32 | Hash table bits 32..63 |
| promisc | input | 1 | Accept every frame |
| rejectBcast | input | 1 | Reject the all-ones address |
| decisionValid | output | 1 | One-cycle decision strobe |
| accept | output | 1 | Decision: 1 keeps the frame |

## Verification
The bench covers each address class in turn:
- Random unicast addresses, exact station matches, and near-misses that differ in a single byte. These separate the full six-byte compare from a partial one.
- Multicast addresses checked against random hash tables. Directed cases set only the selected bit in the lower word and then in the upper word. These expose a wrong CRC, a wrong index slice or a swapped word.
- Broadcast under every combination of the two mode inputs. This shows the priority of promiscuous mode over broadcast rejection, and of broadcast over multicast.
- Idle gaps, restarts in mid-address and trailing bytes. These check the byte counting and the timing of the decision.

// File: rtl/dst_addr_screen_pkg.sv
package dst_addr_screen_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int IDX_W      = $clog2(ADDR_BYTES);
  localparam int CRC_W      = 32;
  localparam int HASH_IDX_W = 6;
  localparam int WORD_W     = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;

  typedef struct packed {
    logic             step;
    logic             first;
    logic             last;
    logic [IDX_W-1:0] idx;
  } strobe_t;

  function automatic logic [CRC_W-1:0] crcByte(input logic [CRC_W-1:0] c,
                                               input logic [7:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/dst_addr_screen_ctrl.sv
module dst_addr_screen_ctrl
  import dst_addr_screen_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    byteValid,
  input  logic    frameStart,
  output strobe_t ctl
);
  logic             busyQ;
  logic [IDX_W-1:0] idxQ;
  logic             stepS, firstS, lastS;
  logic [IDX_W-1:0] idxS;

  always_comb begin
    firstS = byteValid && frameStart;
    stepS  = byteValid && (frameStart || busyQ);
    idxS   = firstS ? '0 : idxQ;
    lastS  = stepS && (idxS == IDX_W'(ADDR_BYTES - 1));
    ctl    = '{step: stepS, first: firstS, last: lastS, idx: idxS};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      idxQ  <= '0;
    end else if (stepS) begin
      if (lastS) begin
        busyQ <= 1'b0;
        idxQ  <= '0;
      end else begin
        busyQ <= 1'b1;
        idxQ  <= idxS + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dst_addr_screen_dp.sv
module dst_addr_screen_dp
  import dst_addr_screen_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           ctl,
  input  logic [7:0]        byteData,
  input  logic [WORD_W-1:0] stationLo,
  input  logic [15:0]       stationHi,
  input  logic [WORD_W-1:0] hashLo,
  input  logic [WORD_W-1:0] hashHi,
  input  logic              promisc,
  input  logic              rejectBcast,
  output logic              decisionValid,
  output logic              accept
);
  localparam int ST_W = 8 * ADDR_BYTES;

  logic [CRC_W-1:0]      crcQ, seed, crcD;
  logic                  uniQ, onesQ, grpQ;
  logic                  uniD, onesD, grpD;
  logic [ST_W-1:0]       stationVec;
  logic [7:0]            stationByte;
  logic [HASH_IDX_W-1:0] hashIdx;
  logic [2*WORD_W-1:0]   table64;
  logic                  hashBit, verdict;

  assign stationVec = {stationHi, stationLo};
  assign table64    = {hashHi, hashLo};

  always_comb begin
    stationByte = stationVec[(ADDR_BYTES - 1 - int'(ctl.idx)) * 8 +: 8];
    seed    = ctl.first ? '1 : crcQ;
    crcD    = crcByte(seed, byteData);
    uniD    = (ctl.first ? 1'b1 : uniQ) && (byteData == stationByte);
    onesD   = (ctl.first ? 1'b1 : onesQ) && (byteData == 8'hFF);
    grpD    = ctl.first ? byteData[0] : grpQ;
    hashIdx = crcD[CRC_W-1 -: HASH_IDX_W];
    hashBit = table64[hashIdx];
    if (promisc)    verdict = 1'b1;
    else if (onesD) verdict = !rejectBcast;
    else if (grpD)  verdict = hashBit;
    else            verdict = uniD;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcQ  <= '1;
      uniQ  <= 1'b0;
      onesQ <= 1'b0;
      grpQ  <= 1'b0;
    end else if (ctl.step) begin
      crcQ  <= crcD;
      uniQ  <= uniD;
      onesQ <= onesD;
      grpQ  <= grpD;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decisionValid <= 1'b0;
      accept        <= 1'b0;
    end else begin
      decisionValid <= ctl.last;
      if (ctl.last) accept <= verdict;
    end
  end
endmodule

// File: rtl/dst_addr_screen.sv
module dst_addr_screen
  import dst_addr_screen_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        byteValid,
  input  logic        frameStart,
  input  logic [7:0]  byteData,
  input  logic [31:0] stationLo,
  input  logic [15:0] stationHi,
  input  logic [31:0] hashLo,
  input  logic [31:0] hashHi,
  input  logic        promisc,
  input  logic        rejectBcast,
  output logic        decisionValid,
  output logic        accept
);
  strobe_t ctlStrobe;

  dst_addr_screen_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid),
    .frameStart(frameStart), .ctl(ctlStrobe)
  );

  dst_addr_screen_dp uDp (
    .clk(clk), .rstN(rstN), .ctl(ctlStrobe), .byteData(byteData),
    .stationLo(stationLo), .stationHi(stationHi),
    .hashLo(hashLo), .hashHi(hashHi),
    .promisc(promisc), .rejectBcast(rejectBcast),
    .decisionValid(decisionValid), .accept(accept)
  );
endmodule

// File: rtl/dst_addr_screen_chk.sv
module dst_addr_screen_chk
  import dst_addr_screen_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       byteValid,
  input logic       frameStart,
  input logic [7:0] byteData,
  input logic       promisc,
  input logic       rejectBcast,
  input strobe_t    ctl,
  input logic       decisionValid,
  input logic       accept
);
  logic allOnesSeen;
  always_ff @(posedge clk) begin
    if (!rstN) allOnesSeen <= 1'b0;
    else if (byteValid && frameStart) allOnesSeen <= (byteData == 8'hFF);
    else if (byteValid) allOnesSeen <= allOnesSeen && (byteData == 8'hFF);
  end

  // R2
  last_to_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.last |=> decisionValid);

  // R2
  no_stray_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.last |=> !decisionValid);

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    decisionValid |=> !decisionValid);

  // R9
  hold_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    !decisionValid |-> $stable(accept));

  // R8
  promisc_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decisionValid && $past(promisc)) |-> accept);

  // R6
  bcast_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decisionValid && allOnesSeen && $past(rejectBcast) && !$past(promisc)) |-> !accept);
endmodule

bind dst_addr_screen dst_addr_screen_chk uChk (
  .clk(clk), .rstN(rstN), .byteValid(byteValid), .frameStart(frameStart),
  .byteData(byteData), .promisc(promisc), .rejectBcast(rejectBcast),
  .ctl(ctlStrobe), .decisionValid(decisionValid), .accept(accept)
);

// File: tb/sim_dst_addr_screen.sv
`timescale 1ns/1ps
module sim_dst_addr_screen;
  logic        clk = 1'b0;
  logic        rstN;
  logic        byteValid, frameStart;
  logic [7:0]  byteData;
  logic [31:0] stationLo, hashLo, hashHi;
  logic [15:0] stationHi;
  logic        promisc, rejectBcast;
  logic        decisionValid, accept;

  int total = 0;
  int bad   = 0;
  bit lastAcc = 1'b0;
  bit [31:0] seedVal = 32'd1234;

  always #5 clk = ~clk;

  dst_addr_screen u0 (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .frameStart(frameStart),
    .byteData(byteData), .stationLo(stationLo), .stationHi(stationHi),
    .hashLo(hashLo), .hashHi(hashHi), .promisc(promisc),
    .rejectBcast(rejectBcast), .decisionValid(decisionValid), .accept(accept)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit [31:0] refCrc(input bit [47:0] a);
    bit [31:0] c = 32'hFFFFFFFF;
    for (int k = 0; k < 6; k++) begin
      bit [7:0] d = a[47 - 8*k -: 8];
      for (int b = 0; b < 8; b++) begin
        bit fb = c[0] ^ d[b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return c;
  endfunction

  function automatic bit [5:0] refIdx(input bit [47:0] a);
    bit [31:0] c = refCrc(a);
    return c[31:26];
  endfunction

  function automatic bit refAccept(input bit [47:0] a);
    bit [5:0] i;
    if (promisc) return 1'b1;
    if (a == 48'hFFFF_FFFF_FFFF) return !rejectBcast;
    if (a[40]) begin
      i = refIdx(a);
      return i[5] ? hashHi[i[4:0]] : hashLo[i[4:0]];
    end
    return a == {stationHi, stationLo};
  endfunction

  task automatic sendByte(input bit [7:0] d, input bit st, input int gap);
    for (int g = 0; g < gap; g++) begin
      byteValid = 1'b0; frameStart = 1'b0; byteData = $urandom;
      @(negedge clk);
      check("R2", decisionValid, 0);
    end
    byteValid = 1'b1; frameStart = st; byteData = d;
    @(negedge clk);
    byteValid = 1'b0; frameStart = 1'b0;
  endtask

  task automatic sendAddr(input bit [47:0] a, input bit gaps, input string req);
    bit exp = refAccept(a);
    for (int k = 0; k < 6; k++) begin
      if (k > 0) check("R2", decisionValid, 0);
      sendByte(a[47 - 8*k -: 8], k == 0, gaps ? int'($urandom_range(0, 2)) : 0);
    end
    check("R2", decisionValid, 1);
    check(req, accept, exp);
    lastAcc = exp;
    @(negedge clk);
    check("R2", decisionValid, 0);
    check("R9", accept, exp);
  endtask

  function automatic bit [47:0] mcastAddr();
    bit [47:0] a = {$urandom, $urandom};
    a[40] = 1'b1;
    if (a == 48'hFFFF_FFFF_FFFF) a[0] = 1'b0;
    return a;
  endfunction

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit [47:0] st, a;
    bit [5:0] ix;
    void'($urandom(seedVal));
    rstN = 1'b0; byteValid = 0; frameStart = 0; byteData = 0;
    stationLo = 32'h3344_5566; stationHi = 16'h0A22;
    hashLo = 0; hashHi = 0; promisc = 0; rejectBcast = 0;
    repeat (3) @(negedge clk);
    check("R1", {decisionValid, accept}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", {decisionValid, accept}, 0);
    st = {stationHi, stationLo};

    // R5 exact and near-miss unicast
    sendAddr(st, 0, "R5");
    for (int k = 0; k < 6; k++) begin
      a = st; a[47 - 8*k -: 8] ^= 8'h10;
      sendAddr(a, 1, "R5");
    end
    // R6 broadcast both ways
    rejectBcast = 0; sendAddr(48'hFFFF_FFFF_FFFF, 0, "R6");
    rejectBcast = 1; sendAddr(48'hFFFF_FFFF_FFFF, 0, "R6");
    // R8 promiscuous overrides rejection and mismatch
    promisc = 1;
    sendAddr(48'hFFFF_FFFF_FFFF, 0, "R8");
    sendAddr(st ^ 48'h1, 0, "R8");
    promisc = 0; rejectBcast = 0;

    // R7 directed: single bit in lower word, then upper word
    for (int want = 0; want < 2; want++) begin
      do begin a = mcastAddr(); ix = refIdx(a); end while (ix[5] != want[0]);
      hashLo = 0; hashHi = 0;
      if (ix[5]) hashHi[ix[4:0]] = 1'b1; else hashLo[ix[4:0]] = 1'b1;
      sendAddr(a, 0, "R7");
      check("R7", accept, 1);
      hashLo = ~hashLo; hashHi = ~hashHi;
      sendAddr(a, 0, "R7");
      check("R7", accept, 0);
    end

    // R3 restart mid-address
    sendByte(8'h55, 1, 0); sendByte(8'h66, 0, 0); sendByte(8'h77, 0, 0);
    check("R3", decisionValid, 0);
    sendAddr(st, 0, "R3");
    check("R3", accept, 1);

    // R4 trailing bytes ignored
    for (int t = 0; t < 8; t++) begin
      sendByte($urandom, 0, 0);
      check("R4", decisionValid, 0);
      check("R4", accept, lastAcc);
    end

    // random mix
    for (int n = 0; n < 300; n++) begin
      int kind = $urandom_range(0, 3);
      hashLo = $urandom; hashHi = $urandom;
      promisc = ($urandom_range(0, 7) == 0);
      rejectBcast = $urandom_range(0, 1);
      case (kind)
        0: begin a = {$urandom, $urandom}; a[40] = 1'b0; end
        1: a = st;
        2: a = mcastAddr();
        default: a = 48'hFFFF_FFFF_FFFF;
      endcase
      sendAddr(a, 1, kind == 2 ? "R7" : (kind == 3 ? "R6" : "R5"));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule